// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the serial configuration slave of a frequency synthesizer. A host drives three pins: a bit clock, a data line and a strobe. Words of 24 bits are shifted in least-significant bit first while the strobe is low. When the strobe rises, shifting freezes and the top bits of the word, which arrive last, select the destination register. Four register groups are held: the main loop ratio with its fractional numerator and modulus, the reference ratio with lock-output mode, loop power bits and compensation DAC code, the auxiliary ratio with pump gain and comparison-tap selects, and two test bits that govern speed-up.

The three serial pins are brought into the system clock domain by synchronizers, and their edges are detected there. The compensation DAC code is double-buffered: a reference/power word only fills a holding register, and the working value changes when the next main-ratio word is latched, so the DAC code and the new ratio take effect together. A main-ratio word also starts a speed-up interval that lasts while the strobe stays high. The effective power enable of each loop is the software bit combined with a hardware pin that inverts its sense.

Top module: `synth_prog_if`

## Requirements
- R1: After reset the outputs hold: main ratio 17504, numerator 4, modulus-5 select 0, reference ratio 81, lock mode 0, main and aux power bits 1, DAC code 80, aux ratio 458, pump gain 3, both selects 0, both test bits 0; speedup is 0.
- R2: Words are shifted LSB first on synchronized rising edges of ser_clk. Address 00 in bits 23:22 loads the main word: bit 21 modulus-5 select, bits 20:18 numerator, bits 17:2 main ratio.
- R3: Address 01 loads the reference/power word: bits 21:12 reference ratio, bits 11:10 lock mode, bit 9 main power bit, bit 8 aux power bit, bits 7:0 DAC code (to the holding register).
- R4: Address 10 loads the aux word: bits 21:8 aux ratio, bits 7:6 pump gain, bits 5:3 main select, bits 2:0 aux select; integ_pump_en is the inverse of pump-gain bit 1.
- R5: Bits 23:21 equal to 110 load the test word (bit 16 speed-up disable, bit 15 speed-up force); bits 23:21 equal to 111 change no register.
- R6: While ser_strobe is high, ser_clk edges do not change the shift register; a second strobe pulse with no shifting in between re-latches the same word.
- R7: comp_dac takes the held DAC code only when a main word is latched; a reference/power word alone leaves comp_dac unchanged.
- R8: After a main word is latched, speedup is 1 while ser_strobe stays high and returns to 0 after it falls.
- R9: With the force test bit set and the disable bit clear, speedup is 1 continuously, regardless of strobe.
- R10: With the disable test bit set, speedup is 0, overriding both force and a main-word interval.
- R11: main_en equals main power bit XOR pwr_pin, and aux_en equals aux power bit XOR pwr_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, LSB first |
| ser_strobe | input | 1 | Latch enable; high freezes shifting |
| pwr_pin | input | 1 | Hardware power-sense inversion |
| main_n | output | 16 | Main integer ratio |
| frac_nf | output | 3 | Fractional numerator |
| frac_mod5 | output | 1 | 1 selects modulus 5, 0 modulus 8 |
| ref_r | output | 10 | Reference ratio |
| lock_mode | output | 2 | Lock output mode |
| comp_dac | output | 8 | Working compensation DAC code |
| aux_n | output | 14 | Aux ratio |
| pump_gain | output | 2 | Pump gain code |
| integ_pump_en | output | 1 | Integral pump enable |
| main_sel | output | 3 | Reference tap for main comparator |
| aux_sel | output | 3 | Reference tap for aux comparator |
| main_en | output | 1 | Effective main loop power enable |
| aux_en | output | 1 | Effective aux loop power enable |
| speedup | output | 1 | Pump speed-up control |

## Verification
The hardest situation to reach from the ports is the pairing of a held DAC code with a later main word while the speed-up interval and test bits interact, because it needs a specific order of several complete serial transfers with the strobe held for a chosen time. The bench drives whole words through a task that shifts each bit and holds the strobe long enough to sample speedup mid-pulse, then follows a directed sequence (reference word, check the old DAC code, main word, check the new one) and later sets force and disable together. Clock pulses sent while the strobe is high are exercised by re-strobing without shifting, so a leaked shift would surface as a changed main word.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W  = 24;
  localparam int N_W     = 16;
  localparam int NF_W    = 3;
  localparam int R_W     = 10;
  localparam int LOCK_W  = 2;
  localparam int DAC_W   = 8;
  localparam int AUXN_W  = 14;
  localparam int GAIN_W  = 2;
  localparam int SEL_W   = 3;

  typedef enum logic [2:0] {K_MAIN, K_REF, K_AUX, K_TEST, K_NONE} word_kind_e;

  typedef struct packed {
    logic              fmod5;
    logic [NF_W-1:0]   nf;
    logic [N_W-1:0]    n;
    logic [R_W-1:0]    r;
    logic [LOCK_W-1:0] lock;
    logic              main_on;
    logic              aux_on;
    logic [DAC_W-1:0]  dac_work;
    logic [AUXN_W-1:0] aux_n;
    logic [GAIN_W-1:0] gain;
    logic [SEL_W-1:0]  msel;
    logic [SEL_W-1:0]  asel;
    logic              t_dis;
    logic              t_force;
  } prog_cfg_t;

  localparam logic [DAC_W-1:0] DAC_RESET = 8'd80;

  localparam prog_cfg_t CFG_RESET = '{
    fmod5: 1'b0, nf: 3'd4, n: 16'd17504, r: 10'd81, lock: 2'd0,
    main_on: 1'b1, aux_on: 1'b1, dac_work: DAC_RESET, aux_n: 14'd458,
    gain: 2'd3, msel: 3'd0, asel: 3'd0, t_dis: 1'b0, t_force: 1'b0};

  // Top three bits of a word pick its destination.
  function automatic word_kind_e classify(input logic [2:0] a);
    case (a[2:1])
      2'b00:   return K_MAIN;
      2'b01:   return K_REF;
      2'b10:   return K_AUX;
      default: return a[0] ? K_NONE : K_TEST;
    endcase
  endfunction

  // Hardware pin inverts the sense of a software power bit.
  function automatic logic eff_enable(input logic sw_bit, input logic pin);
    return sw_bit ^ pin;
  endfunction
endpackage

// File: rtl/synth_ser_shift.sv
module synth_ser_shift
  import synth_prog_pkg::*;
#(
  parameter int W_BITS      = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  output logic [W_BITS-1:0] shift_q,
  output logic              load_p,
  output logic              strb_lvl,
  output logic              strb_fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ck_sy, dt_sy, st_sy;
  logic ck_d, st_d;
  logic ck_s, dt_s, st_s;
  logic shift_evt;

  assign ck_s = ck_sy[TOP];
  assign dt_s = dt_sy[TOP];
  assign st_s = st_sy[TOP];

  assign shift_evt = ck_s & ~ck_d & ~st_s;
  assign load_p    = st_s & ~st_d;
  assign strb_fall = ~st_s & st_d;
  assign strb_lvl  = st_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy   <= '0;
      dt_sy   <= '0;
      st_sy   <= '0;
      ck_d    <= 1'b0;
      st_d    <= 1'b0;
      shift_q <= '0;
    end else begin
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], ser_clk};
      dt_sy <= {dt_sy[SYNC_STAGES-2:0], ser_data};
      st_sy <= {st_sy[SYNC_STAGES-2:0], ser_strobe};
      ck_d  <= ck_s;
      st_d  <= st_s;
      if (shift_evt) shift_q <= {dt_s, shift_q[W_BITS-1:1]};
    end
  end

  p_hold_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb_lvl |=> $stable(shift_q));

  p_load_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |=> !load_p);
endmodule

// File: rtl/synth_word_regs.sv
module synth_word_regs
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_p,
  input  logic [WORD_W-1:0] word,
  output prog_cfg_t         cfg,
  output logic              main_loaded
);
  word_kind_e       kind;
  logic [DAC_W-1:0] dac_hold;

  assign kind        = classify(word[WORD_W-1 -: 3]);
  assign main_loaded = load_p && (kind == K_MAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CFG_RESET;
      dac_hold <= DAC_RESET;
    end else if (load_p) begin
      case (kind)
        K_MAIN: begin
          cfg.fmod5    <= word[21];
          cfg.nf       <= word[20:18];
          cfg.n        <= word[17:2];
          cfg.dac_work <= dac_hold;
        end
        K_REF: begin
          cfg.r       <= word[21:12];
          cfg.lock    <= word[11:10];
          cfg.main_on <= word[9];
          cfg.aux_on  <= word[8];
          dac_hold    <= word[7:0];
        end
        K_AUX: begin
          cfg.aux_n <= word[21:8];
          cfg.gain  <= word[7:6];
          cfg.msel  <= word[5:3];
          cfg.asel  <= word[2:0];
        end
        K_TEST: begin
          cfg.t_dis   <= word[16];
          cfg.t_force <= word[15];
        end
        default: ;
      endcase
    end
  end

  p_dac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !main_loaded |=> $stable(cfg.dac_work));

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && kind == K_NONE) |=> $stable(cfg));
endmodule

// File: rtl/synth_speedup.sv
module synth_speedup (
  input  logic clk,
  input  logic rst_n,
  input  logic main_loaded,
  input  logic strb_fall,
  input  logic t_dis,
  input  logic t_force,
  output logic speedup
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b0;
    else if (main_loaded) armed <= 1'b1;
    else if (strb_fall)   armed <= 1'b0;
  end

  assign speedup = ~t_dis & (t_force | armed);

  p_spu_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !t_force) |=> !speedup);
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  input  logic              pwr_pin,
  output logic [N_W-1:0]    main_n,
  output logic [NF_W-1:0]   frac_nf,
  output logic              frac_mod5,
  output logic [R_W-1:0]    ref_r,
  output logic [LOCK_W-1:0] lock_mode,
  output logic [DAC_W-1:0]  comp_dac,
  output logic [AUXN_W-1:0] aux_n,
  output logic [GAIN_W-1:0] pump_gain,
  output logic              integ_pump_en,
  output logic [SEL_W-1:0]  main_sel,
  output logic [SEL_W-1:0]  aux_sel,
  output logic              main_en,
  output logic              aux_en,
  output logic              speedup
);
  logic [WORD_W-1:0] shift_q;
  logic load_p, strb_lvl, strb_fall, main_loaded;
  prog_cfg_t cfg;

  synth_ser_shift #(.W_BITS(WORD_W), .SYNC_STAGES(2)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .shift_q(shift_q), .load_p(load_p),
    .strb_lvl(strb_lvl), .strb_fall(strb_fall));

  synth_word_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load_p(load_p), .word(shift_q),
    .cfg(cfg), .main_loaded(main_loaded));

  synth_speedup u_spu (
    .clk(clk), .rst_n(rst_n), .main_loaded(main_loaded),
    .strb_fall(strb_fall), .t_dis(cfg.t_dis), .t_force(cfg.t_force),
    .speedup(speedup));

  assign main_n        = cfg.n;
  assign frac_nf       = cfg.nf;
  assign frac_mod5     = cfg.fmod5;
  assign ref_r         = cfg.r;
  assign lock_mode     = cfg.lock;
  assign comp_dac      = cfg.dac_work;
  assign aux_n         = cfg.aux_n;
  assign pump_gain     = cfg.gain;
  assign integ_pump_en = ~cfg.gain[1];
  assign main_sel      = cfg.msel;
  assign aux_sel       = cfg.asel;
  assign main_en       = eff_enable(cfg.main_on, pwr_pin);
  assign aux_en        = eff_enable(cfg.aux_on, pwr_pin);

  p_dis_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.t_dis |-> !speedup);

  p_force_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.t_force && !cfg.t_dis) |-> speedup);
endmodule

// File: tb/tb_synth_prog_if.sv
module tb_synth_prog_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, pwr_pin = 1'b0;
  logic [15:0] main_n; logic [2:0] frac_nf; logic frac_mod5;
  logic [9:0] ref_r; logic [1:0] lock_mode; logic [7:0] comp_dac;
  logic [13:0] aux_n; logic [1:0] pump_gain; logic integ_pump_en;
  logic [2:0] main_sel, aux_sel; logic main_en, aux_en, speedup;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // expected state
  logic e_fmod; logic [2:0] e_nf; logic [15:0] e_n; logic [9:0] e_r;
  logic [1:0] e_lock; logic e_mon, e_aon; logic [7:0] e_dtmp, e_dac;
  logic [13:0] e_auxn; logic [1:0] e_gain; logic [2:0] e_msel, e_asel;
  logic e_dis, e_force;

  always #2 clk = ~clk;

  synth_prog_if dut (.*);

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R2 main_n"}, 32'(main_n), 32'(e_n));
    chk({ctx, " R2 frac_nf"}, 32'(frac_nf), 32'(e_nf));
    chk({ctx, " R2 frac_mod5"}, 32'(frac_mod5), 32'(e_fmod));
    chk({ctx, " R3 ref_r"}, 32'(ref_r), 32'(e_r));
    chk({ctx, " R3 lock_mode"}, 32'(lock_mode), 32'(e_lock));
    chk({ctx, " R7 comp_dac"}, 32'(comp_dac), 32'(e_dac));
    chk({ctx, " R4 aux_n"}, 32'(aux_n), 32'(e_auxn));
    chk({ctx, " R4 pump_gain"}, 32'(pump_gain), 32'(e_gain));
    chk({ctx, " R4 integ_pump_en"}, 32'(integ_pump_en), 32'(!e_gain[1]));
    chk({ctx, " R4 main_sel"}, 32'(main_sel), 32'(e_msel));
    chk({ctx, " R4 aux_sel"}, 32'(aux_sel), 32'(e_asel));
    chk({ctx, " R11 main_en"}, 32'(main_en), 32'(e_mon != pwr_pin));
    chk({ctx, " R11 aux_en"}, 32'(aux_en), 32'(e_aon != pwr_pin));
    chk({ctx, " R9 speedup idle"}, 32'(speedup), 32'(!e_dis && e_force));
  endtask

  task automatic shift_in(input logic [23:0] w);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); ser_data = w[i];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  // whole transfer; speedup sampled mid-strobe
  task automatic xfer(input logic [23:0] w, input bit is_main);
    shift_in(w);
    ser_strobe = 1'b1;
    repeat (12) @(negedge clk);
    chk("R8 speedup during strobe", 32'(speedup), 32'(!e_dis && (e_force || is_main)));
    ser_strobe = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_a(input logic fm, input logic [2:0] nf, input logic [15:0] n);
    e_fmod = fm; e_nf = nf; e_n = n; e_dac = e_dtmp;
    xfer({2'b00, fm, nf, n, 2'b00}, 1'b1);
  endtask

  task automatic send_b(input logic [9:0] r, input logic [1:0] lk, input logic mo,
                        input logic ao, input logic [7:0] d);
    e_r = r; e_lock = lk; e_mon = mo; e_aon = ao; e_dtmp = d;
    xfer({2'b01, r, lk, mo, ao, d}, 1'b0);
  endtask

  task automatic send_c(input logic [13:0] an, input logic [1:0] g,
                        input logic [2:0] ms, input logic [2:0] as);
    e_auxn = an; e_gain = g; e_msel = ms; e_asel = as;
    xfer({2'b10, an, g, ms, as}, 1'b0);
  endtask

  task automatic send_d(input logic dis, input logic frc);
    logic [23:0] w;
    e_dis = dis; e_force = frc;
    w = 24'h0; w[23:21] = 3'b110; w[16] = dis; w[15] = frc;
    xfer(w, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4177));
    e_fmod = 0; e_nf = 4; e_n = 17504; e_r = 81; e_lock = 0; e_mon = 1; e_aon = 1;
    e_dtmp = 80; e_dac = 80; e_auxn = 458; e_gain = 3; e_msel = 0; e_asel = 0;
    e_dis = 0; e_force = 0;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // R7: DAC code held until a main word
    send_b(10'd100, 2'd2, 1'b1, 1'b1, 8'h33);
    check_all("R3/R7 after ref word");
    send_a(1'b1, 3'd7, 16'd512);
    check_all("R2/R7 after main word");
    send_a(1'b0, 3'd3, 16'd65535);
    check_all("R2 max ratio");
    send_c(14'd16383, 2'd1, 3'd5, 3'd3);
    check_all("R4 aux max");
    send_c(14'd128, 2'd2, 3'd4, 3'd1);
    check_all("R4 aux min");

    // R6: clock pulses while strobe high must not shift
    shift_in({2'b00, 1'b1, 3'd2, 16'd40000, 2'b00});
    e_fmod = 1; e_nf = 2; e_n = 40000; e_dac = e_dtmp;
    ser_strobe = 1'b1;
    repeat (12) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      ser_data = 1'b0;
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    ser_strobe = 1'b0;
    repeat (10) @(negedge clk);
    ser_strobe = 1'b1;
    repeat (12) @(negedge clk);
    ser_strobe = 1'b0;
    repeat (10) @(negedge clk);
    check_all("R6 relatch");

    // R5: address 111 ignored
    xfer(24'hE5A5A5, 1'b0);
    check_all("R5 ignored word");

    // R8: speedup ends after strobe falls
    send_a(1'b0, 3'd1, 16'd1000);
    chk("R8 speedup after strobe fall", 32'(speedup), 32'd0);

    // R9 force, R10 disable priority
    send_d(1'b0, 1'b1);
    chk("R9 forced speedup", 32'(speedup), 32'd1);
    send_d(1'b1, 1'b1);
    chk("R10 disable over force", 32'(speedup), 32'd0);
    send_a(1'b1, 3'd5, 16'd2222);
    check_all("R10 main word with disable");
    send_d(1'b0, 1'b0);
    check_all("R5 test word cleared");

    // R11: hardware pin inverts power bits
    pwr_pin = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R11 pin high");
    send_b(10'd4, 2'd3, 1'b0, 1'b1, 8'hFF);
    check_all("R11 pin high bits 0/1");
    pwr_pin = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R11 pin low");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int kind;
      kind = int'($urandom % 4);
      case (kind)
        0: send_a(1'($urandom), 3'($urandom), 16'(512 + ($urandom % 65024)));
        1: send_b(10'(4 + ($urandom % 1020)), 2'($urandom), 1'($urandom),
                  1'($urandom), 8'($urandom));
        2: send_c(14'(128 + ($urandom % 16256)), 2'($urandom), 3'($urandom % 5),
                  3'($urandom % 5));
        default: xfer({3'b111, 21'($urandom)}, 1'b0);
      endcase
      check_all("random");
    end

    done = 1;
    report();
  end
endmodule